// File: doc/BRIEF.md
# Quad Converter Double-Buffered Control Core

This block is the digital control core of a four-channel converter. A serial front end, outside this block, shifts in a 4-bit command, an address and data words. It frames each transfer with an active-low load strobe. The core holds two buffers per channel, each with a code register and a span register. The input buffer receives writes. The active buffer drives the converter. Commands move data from the input buffer into the active buffer, either on their own or combined with a write. A separate active-low load input transfers every channel at once.

The core also handles several supply and power events. An asynchronous active-low clear zeroes the active buffers and the captured command and address. It leaves the input buffers alone, so a later transfer restores the earlier outputs. An active-low integrity flag tells the system that the outputs may not be what it last wrote. Each channel can be put to sleep. Channels are grouped in pairs, and each pair shares a reference amplifier. A shared amplifier is switched off only when both channels of its pair are asleep. A readback word reports the active span and the sleep bit of the channel that the readback select picks.

Top module: `qdac_ctrl_core`

## Requirements
- R1: After power-up reset, every active code is 0, every active span is 4'b0000 (the 0 V to 5 V unipolar range), no channel sleeps, every amplifier enable is 1 and `flag_n` is 0.
- R2: A command runs at the first clock edge where `ld_n` is sampled high after having been sampled low. It uses the `cmd`, `addr`, `din_code` and `din_span` values sampled in the last low cycle, and its results appear after that edge. The codes are: 0000 write input code, 0001 write input span, 0010 transfer input to active, 0011 write input code and transfer, 0100 write input span and transfer, 1110 sleep.
- R3: Commands 0000 and 0001 change only the input buffer. The active outputs do not change until a transfer.
- R4: `addr` values 0 to 3 select one channel and value 15 selects all four channels. Any other value selects no channel.
- R5: While `clr_n` is low, every active code and span is 0 and `flag_n` is 0. The input buffers keep their contents, so a later transfer restores the previous outputs.
- R6: If `clr_n` goes low while a frame is open (`ld_n` low), that frame is dropped. Its closing rising edge runs nothing.
- R7: A clock edge with `ldac_n` sampled low transfers the input buffers of all channels to their active buffers, wakes all channels and releases the flag.
- R8: The update commands (0010, 0011, 0100) and `ldac_n` set `flag_n` to 1. Writes, sleep and unrecognised commands leave it at 0. `vdd_low` high forces it to 0 and takes priority over a release.
- R9: Command 1110 sets the sleep bit of each addressed channel. An update command clears the sleep bit of each channel it addresses.
- R10: `amp_en[p]` is 0 exactly when channels 2p and 2p+1 both sleep.
- R11: `rb_word` carries the active span of channel `rb_sel` in bits [3:0] and that channel's sleep bit in bit 4 (1 = asleep). All higher bits are 0.
- R12: A frame with any other command code changes no output and does not release the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| clr_n | input | 1 | System clear, active low, asynchronous |
| vdd_low | input | 1 | Logic-supply-low indication |
| ld_n | input | 1 | Load/select strobe; low frames a transfer |
| cmd | input | 4 | Command code |
| addr | input | 4 | Channel address (15 = all) |
| din_code | input | 14 | Code data word |
| din_span | input | 4 | Span data word |
| ldac_n | input | 1 | Active-low load of all channels |
| rb_sel | input | 2 | Channel chosen for readback |
| code_out | output | 56 | Active codes, channel n at bits [14n+13:14n] |
| span_out | output | 16 | Active spans, channel n at bits [4n+3:4n] |
| sleep_o | output | 4 | Per-channel sleep state |
| amp_en | output | 2 | Shared reference amplifier enables per pair |
| flag_n | output | 1 | Integrity flag, active low |
| rb_word | output | 8 | Span and sleep readback word |

## Verification
The assertions check the following on every cycle:
- the active buffers read zero while the clear is low;
- the input code is stable across a clear;
- a sleep command sets sleep, and an addressed update clears it;
- the flag rises only after an update or a load;
- an amplifier drops only after a sleep command;
- an unrecognised frame leaves the outputs unchanged.

The bench scenarios are needed for the rest:
- restoring values after a clear;
- dropping a frame that a clear cuts into;
- broadcast and out-of-range addressing;
- the priority of the supply-low indication;
- readback field placement.

These all rely on a history of several commands that no single-cycle property captures.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   typedef enum logic [3:0] {
      OP_WR_CODE      = 4'b0000,
      OP_WR_SPAN      = 4'b0001,
      OP_XFER         = 4'b0010,
      OP_WR_CODE_XFER = 4'b0011,
      OP_WR_SPAN_XFER = 4'b0100,
      OP_SLEEP        = 4'b1110
   } op_e;

   typedef struct packed {
      logic known;
      logic wr_code;
      logic wr_span;
      logic xfer;
      logic sleep;
   } ctl_t;

   function automatic ctl_t decode_op(input logic [3:0] code);
      ctl_t c;
      c = '0;
      case (code)
         OP_WR_CODE:      begin c.known = 1'b1; c.wr_code = 1'b1; end
         OP_WR_SPAN:      begin c.known = 1'b1; c.wr_span = 1'b1; end
         OP_XFER:         begin c.known = 1'b1; c.xfer = 1'b1; end
         OP_WR_CODE_XFER: begin c.known = 1'b1; c.wr_code = 1'b1; c.xfer = 1'b1; end
         OP_WR_SPAN_XFER: begin c.known = 1'b1; c.wr_span = 1'b1; c.xfer = 1'b1; end
         OP_SLEEP:        begin c.known = 1'b1; c.sleep = 1'b1; end
         default:         c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/qdac_frame.sv
module qdac_frame
   import qdac_pkg::*;
#(
   parameter int N_CH     = 4,
   parameter int ADDR_W   = 4,
   parameter int CODE_W   = 14,
   parameter int SPAN_W   = 4,
   parameter int ALL_ADDR = 15
) (
   input  logic              clk,
   input  logic              clr_all_n,
   input  logic              ld_n,
   input  logic [3:0]        cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CODE_W-1:0] din_code,
   input  logic [SPAN_W-1:0] din_span,
   output logic              exec,
   output ctl_t              ctl,
   output logic [N_CH-1:0]   mask,
   output logic [CODE_W-1:0] code_q,
   output logic [SPAN_W-1:0] span_q
);

   logic              ld_q;
   logic              armed;
   logic [3:0]        cmd_q;
   logic [ADDR_W-1:0] addr_q;

   // ld_q clears to 0 so a strobe still low after a clear never opens a frame
   always_ff @(posedge clk or negedge clr_all_n) begin
      if (!clr_all_n) begin
         ld_q   <= 1'b0;
         armed  <= 1'b0;
         cmd_q  <= '0;
         addr_q <= '0;
         code_q <= '0;
         span_q <= '0;
      end else begin
         ld_q <= ld_n;
         if (ld_q && !ld_n)
            armed <= 1'b1;
         else if (exec)
            armed <= 1'b0;
         if (!ld_n) begin
            cmd_q  <= cmd;
            addr_q <= addr;
            code_q <= din_code;
            span_q <= din_span;
         end
      end
   end

   assign exec = ld_n && !ld_q && armed;
   assign ctl  = exec ? decode_op(cmd_q) : '0;

   for (genvar g = 0; g < N_CH; g++) begin : g_mask
      assign mask[g] = (int'(addr_q) == ALL_ADDR) || (int'(addr_q) == g);
   end

   // R2: a command only runs on a rising strobe that closed an open frame
   assert_exec_closes_frame_R2: assert property (@(posedge clk) disable iff (!clr_all_n)
      exec |-> $past(!ld_n));

endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
   parameter int CODE_W = 14,
   parameter int SPAN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_all_n,
   input  logic              sel,
   input  logic              wr_code,
   input  logic              wr_span,
   input  logic              xfer,
   input  logic              sleep_set,
   input  logic              ldac,
   input  logic [CODE_W-1:0] din_code,
   input  logic [SPAN_W-1:0] din_span,
   output logic [SPAN_W-1:0] b1_span,
   output logic [CODE_W-1:0] code,
   output logic [SPAN_W-1:0] span,
   output logic              sleep
);

   logic [CODE_W-1:0] b1_code;
   logic [CODE_W-1:0] nxt_code;
   logic [SPAN_W-1:0] nxt_span;
   logic              do_xfer;

   assign do_xfer  = sel && xfer;
   assign nxt_code = (sel && wr_code) ? din_code : b1_code;
   assign nxt_span = (sel && wr_span) ? din_span : b1_span;

   // input buffer: only power-up reset clears it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b1_code <= '0;
         b1_span <= '0;
      end else begin
         b1_code <= nxt_code;
         b1_span <= nxt_span;
      end
   end

   // active buffer: cleared by power-up reset and by system clear
   always_ff @(posedge clk or negedge clr_all_n) begin
      if (!clr_all_n) begin
         code <= '0;
         span <= '0;
      end else if (do_xfer) begin
         code <= nxt_code;
         span <= nxt_span;
      end else if (ldac) begin
         code <= b1_code;
         span <= b1_span;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sleep <= 1'b0;
      else if (sel && sleep_set)
         sleep <= 1'b1;
      else if (do_xfer || ldac)
         sleep <= 1'b0;
   end

   assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_all_n |-> (code == '0 && span == '0));

   assert_input_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_all_n |=> $stable(b1_code));

   assert_sleep_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && sleep_set) |=> sleep);

   assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && xfer) |=> !sleep);

endmodule

// File: rtl/qdac_status.sv
module qdac_status #(
   parameter int N_CH          = 4,
   parameter int SPAN_W        = 4,
   parameter int RB_W          = 8,
   parameter bit RB_FROM_INPUT = 1'b0
) (
   input  logic [N_CH-1:0]        sleep,
   input  logic [N_CH*SPAN_W-1:0] span_act,
   input  logic [N_CH*SPAN_W-1:0] span_in,
   input  logic [$clog2(N_CH)-1:0] rb_sel,
   output logic [N_CH/2-1:0]      amp_en,
   output logic [RB_W-1:0]        rb_word
);

   localparam int N_PAIR = N_CH / 2;

   logic [N_CH*SPAN_W-1:0] span_src;
   logic [SPAN_W-1:0]      span_pick;

   for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
      assign amp_en[p] = !(sleep[2*p] && sleep[2*p+1]);
   end

   if (RB_FROM_INPUT) begin : g_rb_in
      assign span_src = span_in;
   end else begin : g_rb_act
      assign span_src = span_act;
   end

   assign span_pick = span_src[rb_sel*SPAN_W +: SPAN_W];

   always_comb begin
      rb_word              = '0;
      rb_word[SPAN_W-1:0]  = span_pick;
      rb_word[SPAN_W]      = sleep[rb_sel];
   end

endmodule

// File: rtl/qdac_ctrl_core.sv
module qdac_ctrl_core
   import qdac_pkg::*;
#(
   parameter int N_CH          = 4,
   parameter int ADDR_W        = 4,
   parameter int CODE_W        = 14,
   parameter int SPAN_W        = 4,
   parameter int RB_W          = 8,
   parameter int ALL_ADDR      = 15,
   parameter bit RB_FROM_INPUT = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_n,
   input  logic                     vdd_low,
   input  logic                     ld_n,
   input  logic [3:0]               cmd,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [CODE_W-1:0]        din_code,
   input  logic [SPAN_W-1:0]        din_span,
   input  logic                     ldac_n,
   input  logic [$clog2(N_CH)-1:0]  rb_sel,
   output logic [N_CH*CODE_W-1:0]   code_out,
   output logic [N_CH*SPAN_W-1:0]   span_out,
   output logic [N_CH-1:0]          sleep_o,
   output logic [N_CH/2-1:0]        amp_en,
   output logic                     flag_n,
   output logic [RB_W-1:0]          rb_word
);

   localparam int N_PAIR = N_CH / 2;

   if (N_CH % 2 != 0) begin : g_bad_nch
      $error("channel count must be even for paired amplifiers");
   end
   if (RB_W < SPAN_W + 1) begin : g_bad_rbw
      $error("readback word too narrow for span and sleep bit");
   end
   if (ALL_ADDR < N_CH || ALL_ADDR >= (1 << ADDR_W)) begin : g_bad_all
      $error("broadcast address must lie above the channel range");
   end

   logic              clr_all_n;
   logic              exec;
   ctl_t              ctl;
   logic [N_CH-1:0]   mask;
   logic [CODE_W-1:0] code_q;
   logic [SPAN_W-1:0] span_q;
   logic [N_CH*SPAN_W-1:0] span_in;
   logic              upd_any;

   assign clr_all_n = rst_n && clr_n;

   qdac_frame #(
      .N_CH(N_CH), .ADDR_W(ADDR_W), .CODE_W(CODE_W),
      .SPAN_W(SPAN_W), .ALL_ADDR(ALL_ADDR)
   ) frame_i (
      .clk(clk), .clr_all_n(clr_all_n), .ld_n(ld_n), .cmd(cmd),
      .addr(addr), .din_code(din_code), .din_span(din_span),
      .exec(exec), .ctl(ctl), .mask(mask), .code_q(code_q), .span_q(span_q)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_chan
      qdac_chan #(.CODE_W(CODE_W), .SPAN_W(SPAN_W)) chan_i (
         .clk(clk), .rst_n(rst_n), .clr_all_n(clr_all_n),
         .sel(mask[c]), .wr_code(ctl.wr_code), .wr_span(ctl.wr_span),
         .xfer(ctl.xfer), .sleep_set(ctl.sleep), .ldac(!ldac_n),
         .din_code(code_q), .din_span(span_q),
         .b1_span(span_in[c*SPAN_W +: SPAN_W]),
         .code(code_out[c*CODE_W +: CODE_W]),
         .span(span_out[c*SPAN_W +: SPAN_W]),
         .sleep(sleep_o[c])
      );
   end

   qdac_status #(
      .N_CH(N_CH), .SPAN_W(SPAN_W), .RB_W(RB_W), .RB_FROM_INPUT(RB_FROM_INPUT)
   ) status_i (
      .sleep(sleep_o), .span_act(span_out), .span_in(span_in),
      .rb_sel(rb_sel), .amp_en(amp_en), .rb_word(rb_word)
   );

   assign upd_any = (exec && ctl.xfer) || !ldac_n;

   always_ff @(posedge clk or negedge clr_all_n) begin
      if (!clr_all_n)
         flag_n <= 1'b0;
      else if (vdd_low)
         flag_n <= 1'b0;
      else if (upd_any)
         flag_n <= 1'b1;
   end

   assert_flag_release_R8: assert property (@(posedge clk) disable iff (!clr_all_n)
      $rose(flag_n) |-> $past(upd_any));

   assert_unknown_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && !ctl.known && ldac_n) |=>
         (!clr_n || ($stable(code_out) && $stable(span_out) && $stable(sleep_o))));

   for (genvar p = 0; p < N_PAIR; p++) begin : g_amp_chk
      assert_amp_off_after_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(amp_en[p]) |-> $past(exec && ctl.sleep));
   end

endmodule

// File: tb/qdac_ctrl_core_tb_top.sv
`timescale 1ns/1ps
module qdac_ctrl_core_tb_top;

   localparam int NC = 4;
   localparam int CW = 14;
   localparam int SW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0, clr_n = 1'b1, vdd_low = 1'b0, ld_n = 1'b1, ldac_n = 1'b1;
   logic [3:0] cmd = '0, addr = '0;
   logic [CW-1:0] din_code = '0;
   logic [SW-1:0] din_span = '0;
   logic [1:0] rb_sel = '0;
   logic [NC*CW-1:0] code_out;
   logic [NC*SW-1:0] span_out;
   logic [NC-1:0] sleep_o;
   logic [1:0] amp_en;
   logic flag_n;
   logic [7:0] rb_word;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   qdac_ctrl_core dut_i (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .vdd_low(vdd_low), .ld_n(ld_n),
      .cmd(cmd), .addr(addr), .din_code(din_code), .din_span(din_span),
      .ldac_n(ldac_n), .rb_sel(rb_sel), .code_out(code_out), .span_out(span_out),
      .sleep_o(sleep_o), .amp_en(amp_en), .flag_n(flag_n), .rb_word(rb_word)
   );

   // reference model state
   logic [CW-1:0] m_b1c [NC];
   logic [SW-1:0] m_b1s [NC];
   logic [CW-1:0] m_b2c [NC];
   logic [SW-1:0] m_b2s [NC];
   logic          m_slp [NC];
   logic          m_flag;

   typedef struct {
      logic [NC*CW-1:0] code;
      logic [NC*SW-1:0] span;
      logic [NC-1:0]    slp;
      logic [1:0]       amp;
      logic             flag;
      logic [7:0]       rb;
      string            req;
   } exp_t;

   exp_t sb_q[$];

   task automatic model_reset();
      for (int i = 0; i < NC; i++) begin
         m_b1c[i] = '0; m_b1s[i] = '0; m_b2c[i] = '0; m_b2s[i] = '0; m_slp[i] = 1'b0;
      end
      m_flag = 1'b0;
   endtask

   task automatic model_exec(input logic [3:0] c, input logic [3:0] a,
                             input logic [CW-1:0] dc, input logic [SW-1:0] ds);
      bit hit;
      bit upd;
      upd = (c == 4'b0010) || (c == 4'b0011) || (c == 4'b0100);
      for (int i = 0; i < NC; i++) begin
         hit = (a == 4'd15) || (a == 4'(i));
         if (hit) begin
            if (c == 4'b0000 || c == 4'b0011) m_b1c[i] = dc;
            if (c == 4'b0001 || c == 4'b0100) m_b1s[i] = ds;
            if (upd) begin
               m_b2c[i] = m_b1c[i]; m_b2s[i] = m_b1s[i]; m_slp[i] = 1'b0;
            end
            if (c == 4'b1110) m_slp[i] = 1'b1;
         end
      end
      if (upd) m_flag = 1'b1;
   endtask

   task automatic drive_slot();
      @(negedge clk);
      #1;
   endtask

   task automatic frame(input logic [3:0] c, input logic [3:0] a,
                        input logic [CW-1:0] dc, input logic [SW-1:0] ds);
      drive_slot();
      ld_n = 1'b0; cmd = c; addr = a; din_code = dc; din_span = ds;
      drive_slot();
      ld_n = 1'b1;
      @(posedge clk);
      model_exec(c, a, dc, ds);
   endtask

   // called right after a posedge; the monitor compares at the next negedge
   task automatic expect_now(input string req, input logic [1:0] sel);
      exp_t e;
      rb_sel = sel;
      for (int i = 0; i < NC; i++) begin
         e.code[i*CW +: CW] = m_b2c[i];
         e.span[i*SW +: SW] = m_b2s[i];
         e.slp[i] = m_slp[i];
      end
      for (int p = 0; p < 2; p++) e.amp[p] = !(m_slp[2*p] && m_slp[2*p+1]);
      e.flag = m_flag;
      e.rb = {3'b000, m_slp[sel], m_b2s[sel]};
      e.req = req;
      sb_q.push_back(e);
   endtask

   task automatic cmp(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         cmp(e.req, "code_out", 64'(code_out), 64'(e.code));
         cmp(e.req, "span_out", 64'(span_out), 64'(e.span));
         cmp(e.req, "sleep_o",  64'(sleep_o),  64'(e.slp));
         cmp(e.req, "amp_en",   64'(amp_en),   64'(e.amp));
         cmp(e.req, "flag_n",   64'(flag_n),   64'(e.flag));
         cmp(e.req, "rb_word",  64'(rb_word),  64'(e.rb));
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      drive_slot();
      rst_n = 1'b1;
      @(posedge clk);
      expect_now("R1 reset state", 2'd0);

      // R3: writes reach the input buffer only; flag stays low (R8)
      frame(4'b0000, 4'd0, 14'h1234, 4'h0);
      expect_now("R3 code write held", 2'd0);
      frame(4'b0001, 4'd0, 14'h0000, 4'h5);
      expect_now("R3 span write held R8", 2'd0);

      // R2: transfer makes them active, releases flag
      frame(4'b0010, 4'd0, 14'h0, 4'h0);
      expect_now("R2 transfer R8", 2'd0);

      // R4: broadcast write+transfer
      frame(4'b0011, 4'd15, 14'h0abc, 4'h0);
      expect_now("R4 broadcast", 2'd1);
      frame(4'b0100, 4'd2, 14'h0, 4'h3);
      expect_now("R2 span write+transfer", 2'd2);
      // R4: out-of-range address touches nothing
      frame(4'b0011, 4'd7, 14'h3fff, 4'h0);
      expect_now("R4 address 7 ignored", 2'd3);

      // R12: unrecognised code ignored
      frame(4'b1010, 4'd15, 14'h1111, 4'h7);
      expect_now("R12 unknown code", 2'd2);

      // R9 / R10 / R11: sleep handling and readback
      frame(4'b1110, 4'd0, 14'h0, 4'h0);
      expect_now("R9 sleep ch0 R11", 2'd0);
      frame(4'b1110, 4'd1, 14'h0, 4'h0);
      expect_now("R10 pair off", 2'd1);
      frame(4'b0010, 4'd1, 14'h0, 4'h0);
      expect_now("R9 wake by update R10", 2'd1);

      // R5: clear zeroes active side, input kept
      drive_slot();
      clr_n = 1'b0;
      @(posedge clk);
      for (int i = 0; i < NC; i++) begin m_b2c[i] = '0; m_b2s[i] = '0; end
      m_flag = 1'b0;
      expect_now("R5 clear", 2'd0);
      drive_slot();
      clr_n = 1'b1;
      frame(4'b0010, 4'd15, 14'h0, 4'h0);
      expect_now("R5 restore after clear", 2'd0);

      // R6: clear inside open frame drops it
      drive_slot();
      ld_n = 1'b0; cmd = 4'b0011; addr = 4'd3; din_code = 14'h2222;
      drive_slot();
      clr_n = 1'b0;
      @(posedge clk);
      for (int i = 0; i < NC; i++) begin m_b2c[i] = '0; m_b2s[i] = '0; end
      m_flag = 1'b0;
      drive_slot();
      clr_n = 1'b1;
      drive_slot();
      ld_n = 1'b1;
      @(posedge clk);
      expect_now("R6 aborted frame", 2'd3);

      // R8: supply-low holds flag against a load
      frame(4'b0010, 4'd15, 14'h0, 4'h0);
      expect_now("R8 released", 2'd3);
      drive_slot();
      vdd_low = 1'b1; ldac_n = 1'b0;
      @(posedge clk);
      m_flag = 1'b0;
      for (int i = 0; i < NC; i++) begin m_b2c[i] = m_b1c[i]; m_b2s[i] = m_b1s[i]; m_slp[i] = 1'b0; end
      expect_now("R8 vdd_low priority", 2'd3);
      drive_slot();
      vdd_low = 1'b0; ldac_n = 1'b1;
      frame(4'b1110, 4'd2, 14'h0, 4'h0);
      expect_now("R8 sleep keeps flag low", 2'd2);

      // R7: load input wakes and transfers all
      frame(4'b0000, 4'd1, 14'h3fff, 4'h0);
      expect_now("R3 write before load", 2'd1);
      drive_slot();
      ldac_n = 1'b0;
      @(posedge clk);
      for (int i = 0; i < NC; i++) begin m_b2c[i] = m_b1c[i]; m_b2s[i] = m_b1s[i]; m_slp[i] = 1'b0; end
      m_flag = 1'b1;
      expect_now("R7 load all", 2'd2);
      drive_slot();
      ldac_n = 1'b1;

      repeat (3) @(posedge clk);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule